// File: doc/BRIEF.md
# BSSID Mask Receive Filter

This block decides whether a received frame should be acknowledged by the station. It compares the frame's 48-bit BSSID with the station's own MAC address, looking only at the bit positions a programmable 48-bit mask selects. One masked compare serves several virtual BSSes at once. It does not need a table of exact-match entries. As a consequence, some frames meant for other networks also pass. This is intended and is not reported as an error.

Software loads the own address and the active mask through a 32-bit register write port. Each value goes in as a low word and a high 16-bit field, and the same registers can be read back. The high address field shares a register with 16 unrelated control bits, and an address write leaves those bits alone. A mask accumulator helps build the mask. It starts at all ones, and every BSSID fed to it clears the bits where that BSSID differs from the own MAC. A load strobe then copies the accumulated value into the active mask. Frames arrive with a valid strobe, and the accept decision comes back one clock later with its own valid flag.

Top module: `bssid_mask_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the following reset values are set. The own address becomes zero, the control bits become zero, the active mask becomes all ones, the accumulator becomes all ones, and `ack_valid` becomes 0.
- R2: A frame presented with `frm_valid` produces `ack_valid`=1 on the next clock. In that cycle `ack_accept`=1 exactly when (frame AND mask) equals (own address AND mask) over all 48 bits.
- R3: With the active mask all ones, only a frame equal to the own address is accepted.
- R4: Address byte k occupies bits 8k+7:8k of every 48-bit value. Register select 0 writes bits 31:0 of the own address. Select 1 writes bits 47:32 from `reg_wdata[15:0]`.
- R5: Select 1 changes only bits 15:0 of the combined register, and select 2 changes only its bits 31:16 (the control bits). Reading select 1 or select 2 returns {control bits, address bits 47:32}.
- R6: Select 3 writes mask bits 31:0. Select 4 writes mask bits 47:32 from `reg_wdata[15:0]` and reads back as {16'h0, mask bits 47:32}.
- R7: `acc_clear` sets the accumulator to all ones and takes priority over `acc_add`. Without a clear, `acc_add` sets the accumulator to acc AND NOT(own address XOR `acc_bssid`).
- R8: `acc_load` copies the accumulator into the active mask on the next clock. This takes priority over a mask register write in the same cycle.
- R9: Take an own address whose low nibble is 1, with BSSIDs that match it above the low nibble and have low nibbles 4 and 9. The accumulated mask is then 48'hFFFF_FFFF_FFF2. Frames with low nibbles 1, 4, 9 and D are accepted, and a frame with low nibble 6 is rejected.
- R10: A cycle without `frm_valid` gives `ack_valid`=0 on the next clock, and `ack_accept` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for writes |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 3 | Register select for reads |
| reg_rdata | output | 32 | Read data for `reg_rsel` (combinational) |
| acc_clear | input | 1 | Return accumulator to all ones |
| acc_add | input | 1 | Fold `acc_bssid` into the accumulator |
| acc_bssid | input | 48 | BSSID served by this station |
| acc_load | input | 1 | Copy accumulator into the active mask |
| acc_mask | output | 48 | Current accumulator value |
| frm_valid | input | 1 | Frame BSSID valid strobe |
| frm_bssid | input | 48 | BSSID of the received frame |
| ack_valid | output | 1 | Decision valid, one clock after `frm_valid` |
| ack_accept | output | 1 | Frame should be acknowledged |

## Verification
Two cases are hard to reach from the ports. One is a foreign frame that passes only because of the mask. The other is a same-cycle collision between a load and a mask write, or between a clear and an add. The bench builds the mask through the accumulator from a scaled copy of the nibble example and then sends the foreign frame. It also drives the colliding strobes in the same cycle and reads the result back through the register port. The upper control bits are set to a known pattern before the address high field is rewritten, so that any disturbance to them shows up on read-back.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
  localparam int ADDR_W = 48;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_CTRL_HI = 3'd2,
    SEL_MASK_LO = 3'd3,
    SEL_MASK_HI = 3'd4
  } reg_sel_e;

  // Masked equality of a frame BSSID against the own address.
  function automatic logic masked_eq(input logic [ADDR_W-1:0] frame,
                                     input logic [ADDR_W-1:0] mac,
                                     input logic [ADDR_W-1:0] mask);
    return ((frame & mask) == (mac & mask));
  endfunction

  // One accumulation step: drop bits where bssid differs from mac.
  function automatic logic [ADDR_W-1:0] mask_fold(input logic [ADDR_W-1:0] acc,
                                                  input logic [ADDR_W-1:0] mac,
                                                  input logic [ADDR_W-1:0] bssid);
    return acc & ~(mac ^ bssid);
  endfunction
endpackage

// File: rtl/bmf_regs.sv
module bmf_regs #(
  parameter int ADDR_W = bmf_pkg::ADDR_W,
  parameter int WORD_W = bmf_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [2:0]        sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [2:0]        rsel,
  output logic [WORD_W-1:0] rdata,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_mask,
  output logic [ADDR_W-1:0] own_mac,
  output logic [ADDR_W-1:0] act_mask,
  output logic [WORD_W-(ADDR_W-WORD_W)-1:0] ctrl_hi
);
  import bmf_pkg::*;
  localparam int HI_W   = ADDR_W - WORD_W;
  localparam int CTRL_W = WORD_W - HI_W;

  logic [WORD_W-1:0] mac_lo_q, mask_lo_q;
  logic [HI_W-1:0]   mac_hi_q, mask_hi_q;
  logic [CTRL_W-1:0] ctrl_q;

  logic we_addr_lo, we_addr_hi, we_ctrl, we_mask_lo, we_mask_hi;
  assign we_addr_lo = wr && (reg_sel_e'(sel) == SEL_ADDR_LO);
  assign we_addr_hi = wr && (reg_sel_e'(sel) == SEL_ADDR_HI);
  assign we_ctrl    = wr && (reg_sel_e'(sel) == SEL_CTRL_HI);
  assign we_mask_lo = wr && (reg_sel_e'(sel) == SEL_MASK_LO);
  assign we_mask_hi = wr && (reg_sel_e'(sel) == SEL_MASK_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      mac_lo_q  <= '0;
      mac_hi_q  <= '0;
      ctrl_q    <= '0;
      mask_lo_q <= '1;
      mask_hi_q <= '1;
    end else begin
      if (we_addr_lo) mac_lo_q <= wdata;
      if (we_addr_hi) mac_hi_q <= wdata[HI_W-1:0];
      if (we_ctrl)    ctrl_q   <= wdata[WORD_W-1:HI_W];
      if (load_en) begin
        mask_lo_q <= load_mask[WORD_W-1:0];
        mask_hi_q <= load_mask[ADDR_W-1:WORD_W];
      end else begin
        if (we_mask_lo) mask_lo_q <= wdata;
        if (we_mask_hi) mask_hi_q <= wdata[HI_W-1:0];
      end
    end
  end

  always_comb begin
    case (reg_sel_e'(rsel))
      SEL_ADDR_LO: rdata = mac_lo_q;
      SEL_ADDR_HI: rdata = {ctrl_q, mac_hi_q};
      SEL_CTRL_HI: rdata = {ctrl_q, mac_hi_q};
      SEL_MASK_LO: rdata = mask_lo_q;
      SEL_MASK_HI: rdata = {{CTRL_W{1'b0}}, mask_hi_q};
      default:     rdata = '0;
    endcase
  end

  assign own_mac  = {mac_hi_q, mac_lo_q};
  assign act_mask = {mask_hi_q, mask_lo_q};
  assign ctrl_hi  = ctrl_q;
endmodule

// File: rtl/bmf_mask_acc.sv
module bmf_mask_acc #(
  parameter int ADDR_W = bmf_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              add,
  input  logic [ADDR_W-1:0] bssid,
  input  logic [ADDR_W-1:0] own_mac,
  output logic [ADDR_W-1:0] acc
);
  import bmf_pkg::*;
  logic [ADDR_W-1:0] acc_q, acc_next;

  always_comb begin
    acc_next = acc_q;
    if (clear)    acc_next = '1;
    else if (add) acc_next = mask_fold(acc_q, own_mac, bssid);
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '1;
    else     acc_q <= acc_next;
  end

  assign acc = acc_q;
endmodule

// File: rtl/bmf_match.sv
module bmf_match #(
  parameter int ADDR_W = bmf_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [ADDR_W-1:0] bssid,
  input  logic [ADDR_W-1:0] own_mac,
  input  logic [ADDR_W-1:0] mask,
  output logic              ack_valid,
  output logic              accept,
  output logic              hit
);
  localparam int LANES = (ADDR_W + 7) / 8;
  logic [LANES-1:0] lane_hit;

  // Byte-lane compare; a lane passes when all of its unmasked bits agree.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LO = g * 8;
    localparam int HI = ((g * 8 + 7) < ADDR_W) ? (g * 8 + 7) : (ADDR_W - 1);
    assign lane_hit[g] = ((bssid[HI:LO] ^ own_mac[HI:LO]) & mask[HI:LO]) == '0;
  end

  assign hit = &lane_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_valid <= 1'b0;
      accept    <= 1'b0;
    end else begin
      ack_valid <= valid;
      if (valid) accept <= hit;
    end
  end
endmodule

// File: rtl/bssid_mask_filter.sv
module bssid_mask_filter #(
  parameter int ADDR_W = bmf_pkg::ADDR_W,
  parameter int WORD_W = bmf_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  input  logic [2:0]        reg_rsel,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              acc_clear,
  input  logic              acc_add,
  input  logic [ADDR_W-1:0] acc_bssid,
  input  logic              acc_load,
  output logic [ADDR_W-1:0] acc_mask,
  input  logic              frm_valid,
  input  logic [ADDR_W-1:0] frm_bssid,
  output logic              ack_valid,
  output logic              ack_accept
);
  localparam int CTRL_W = WORD_W - (ADDR_W - WORD_W);

  logic [ADDR_W-1:0] own_mac;
  logic [ADDR_W-1:0] act_mask;
  logic [CTRL_W-1:0] ctrl_hi;
  logic              frame_hit;

  bmf_regs #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rsel(reg_rsel), .rdata(reg_rdata), .load_en(acc_load), .load_mask(acc_mask),
    .own_mac(own_mac), .act_mask(act_mask), .ctrl_hi(ctrl_hi)
  );

  bmf_mask_acc #(.ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .clear(acc_clear), .add(acc_add), .bssid(acc_bssid),
    .own_mac(own_mac), .acc(acc_mask)
  );

  bmf_match #(.ADDR_W(ADDR_W)) u_match (
    .clk(clk), .rst(rst), .valid(frm_valid), .bssid(frm_bssid),
    .own_mac(own_mac), .mask(act_mask), .ack_valid(ack_valid),
    .accept(ack_accept), .hit(frame_hit)
  );
endmodule

// File: rtl/bmf_checker.sv
module bmf_checker #(
  parameter int ADDR_W = 48,
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [2:0]        reg_sel,
  input logic              acc_clear,
  input logic              acc_add,
  input logic              acc_load,
  input logic [ADDR_W-1:0] acc_mask,
  input logic              frm_valid,
  input logic [ADDR_W-1:0] frm_bssid,
  input logic              ack_valid,
  input logic              ack_accept,
  input logic [ADDR_W-1:0] own_mac,
  input logic [ADDR_W-1:0] act_mask,
  input logic [CTRL_W-1:0] ctrl_hi
);
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    frm_valid |=> ack_valid); // R2
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> !ack_valid); // R10
  AST_ACCEPT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !frm_valid |=> $stable(ack_accept)); // R10
  AST_EXACT_LOCK: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && (&act_mask)) |=> (ack_accept == ($past(frm_bssid) == $past(own_mac)))); // R3
  AST_CLEAR_ONES: assert property (@(posedge clk) disable iff (rst)
    acc_clear |=> (&acc_mask)); // R7
  AST_ACC_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    (acc_add && !acc_clear) |=> ((acc_mask & ~$past(acc_mask)) == '0)); // R7
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    acc_load |=> (act_mask == $past(acc_mask))); // R8
  AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 3'd1) |=> $stable(ctrl_hi)); // R5
endmodule

bind bssid_mask_filter bmf_checker #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .acc_clear(acc_clear), .acc_add(acc_add), .acc_load(acc_load),
  .acc_mask(acc_mask), .frm_valid(frm_valid), .frm_bssid(frm_bssid),
  .ack_valid(ack_valid), .ack_accept(ack_accept), .own_mac(own_mac),
  .act_mask(act_mask), .ctrl_hi(ctrl_hi)
);

// File: tb/bssid_mask_filter_test.sv
`timescale 1ns/1ps
module bssid_mask_filter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_rsel = '0;
  logic [31:0] reg_rdata;
  logic        acc_clear = 1'b0, acc_add = 1'b0, acc_load = 1'b0;
  logic [47:0] acc_bssid = '0;
  logic [47:0] acc_mask;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_bssid = '0;
  logic        ack_valid, ack_accept;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  bssid_mask_filter uut (.*);

  always #5 clk = ~clk;

  typedef struct packed {
    logic [47:0] mac;
    logic [47:0] mask;
    logic [47:0] frame;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{48'h1234_5678_9ABC, 48'hFFFF_FFFF_FFFF, 48'h1234_5678_9ABC, 1'b1},
    '{48'h1234_5678_9ABC, 48'hFFFF_FFFF_FFFF, 48'h1234_5678_9ABD, 1'b0},
    '{48'h1234_5678_9ABC, 48'h0000_0000_0000, 48'hFFFF_FFFF_FFFF, 1'b1},
    '{48'h1234_5678_9ABC, 48'hFFFF_0000_0000, 48'h1234_0000_0000, 1'b1},
    '{48'h1234_5678_9ABC, 48'hFFFF_0000_0000, 48'h1235_5678_9ABC, 1'b0},
    '{48'h1234_5678_9ABC, 48'h0000_0000_00FF, 48'hAAAA_AAAA_AABC, 1'b1},
    '{48'h0000_0000_0000, 48'h8000_0000_0000, 48'h8000_0000_0000, 1'b0},
    '{48'h0000_0000_0001, 48'h8000_0000_0001, 48'h7FFF_FFFF_FFFF, 1'b1}
  };

  localparam logic [47:0] BASE = 48'h0A1B_2C3D_4E50;

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic set_mac(input logic [47:0] m);
    wr(3'd0, m[31:0]);
    wr(3'd1, {16'h0, m[47:32]});
  endtask

  task automatic set_mask(input logic [47:0] m);
    wr(3'd3, m[31:0]);
    wr(3'd4, {16'h0, m[47:32]});
  endtask

  // Present one frame; return accept seen in the cycle after the strobe.
  task automatic send(input logic [47:0] f, output logic acc, output logic vld);
    @(negedge clk);
    frm_valid = 1'b1; frm_bssid = f;
    @(negedge clk);
    frm_valid = 1'b0;
    acc = ack_accept; vld = ack_valid;
  endtask

  task automatic acc_step(input logic clr, input logic add, input logic [47:0] b);
    @(negedge clk);
    acc_clear = clr; acc_add = add; acc_bssid = b;
    @(negedge clk);
    acc_clear = 1'b0; acc_add = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_rsel = s;
    #1 d = reg_rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic a, v;
    logic [31:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, d); check("R1 addr lo", {16'h0, d}, 48'h0);
    rd(3'd1, d); check("R1 addr hi/ctrl", {16'h0, d}, 48'h0);
    rd(3'd3, d); check("R1 mask lo", {16'h0, d}, 48'hFFFF_FFFF);
    rd(3'd4, d); check("R1 mask hi", {16'h0, d}, 48'h0000_FFFF);
    check("R1 acc", acc_mask, 48'hFFFF_FFFF_FFFF);
    check("R1 ack_valid", {47'h0, ack_valid}, 48'h0);

    // R2/R3 vector table
    for (int i = 0; i < 8; i++) begin
      set_mac(VECS[i].mac);
      set_mask(VECS[i].mask);
      send(VECS[i].frame, a, v);
      check("R2 valid", {47'h0, v}, 48'h1);
      check((VECS[i].mask == '1) ? "R3 exact" : "R2 masked", {47'h0, a}, {47'h0, VECS[i].exp});
    end

    // R10 idle cycle: no valid, accept held (last vector accepted)
    @(negedge clk);
    check("R10 no ack_valid", {47'h0, ack_valid}, 48'h0);
    check("R10 accept held", {47'h0, ack_accept}, 48'h1);

    // R4 byte order
    set_mask(48'hFFFF_FFFF_FFFF);
    wr(3'd0, 32'h4433_2211);
    wr(3'd1, 32'hFFFF_6655);
    send(48'h6655_4433_2211, a, v);
    check("R4 byte order accept", {47'h0, a}, 48'h1);
    rd(3'd0, d); check("R4 low word", {16'h0, d}, 48'h4433_2211);

    // R5 control bits kept
    wr(3'd2, 32'hABCD_1234);
    rd(3'd1, d); check("R5 ctrl write", {16'h0, d}, 48'hABCD_6655);
    wr(3'd1, 32'hFFFF_7788);
    rd(3'd2, d); check("R5 ctrl kept", {16'h0, d}, 48'hABCD_7788);

    // R6 mask read-back
    set_mask(48'h5A5A_0F0F_F0F0);
    rd(3'd3, d); check("R6 mask lo", {16'h0, d}, 48'h0F0F_F0F0);
    rd(3'd4, d); check("R6 mask hi", {16'h0, d}, 48'h0000_5A5A);

    // R7/R9 accumulate scaled example
    set_mac(BASE | 48'h1);
    acc_step(1'b1, 1'b0, '0);
    check("R7 clear", acc_mask, 48'hFFFF_FFFF_FFFF);
    acc_step(1'b0, 1'b1, BASE | 48'h4);
    check("R7 fold 1", acc_mask, 48'hFFFF_FFFF_FFFA);
    acc_step(1'b0, 1'b1, BASE | 48'h9);
    check("R9 mask", acc_mask, 48'hFFFF_FFFF_FFF2);
    @(negedge clk); acc_load = 1'b1;
    @(negedge clk); acc_load = 1'b0;
    rd(3'd3, d); check("R8 loaded lo", {16'h0, d}, 48'hFFFF_FFF2);
    send(BASE | 48'h1, a, v); check("R9 frame 1", {47'h0, a}, 48'h1);
    send(BASE | 48'h6, a, v); check("R9 frame 6", {47'h0, a}, 48'h0);
    send(BASE | 48'h4, a, v); check("R9 frame 4", {47'h0, a}, 48'h1);
    send(BASE | 48'h9, a, v); check("R9 frame 9", {47'h0, a}, 48'h1);
    send(BASE | 48'hD, a, v); check("R9 foreign D", {47'h0, a}, 48'h1);
    send(BASE ^ 48'h1000_0000_0001, a, v); check("R9 upper diff", {47'h0, a}, 48'h0);

    // R7 clear wins over add
    acc_step(1'b1, 1'b1, 48'h0);
    check("R7 clear priority", acc_mask, 48'hFFFF_FFFF_FFFF);

    // R8 load wins over same-cycle mask write
    @(negedge clk);
    acc_load = 1'b1; reg_wr = 1'b1; reg_sel = 3'd3; reg_wdata = 32'h1234_5678;
    @(negedge clk);
    acc_load = 1'b0; reg_wr = 1'b0;
    rd(3'd3, d); check("R8 load priority", {16'h0, d}, 48'hFFFF_FFFF);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule